// File: doc/BRIEF.md
# Multi-format stereo audio serial receiver

This block turns a two-channel serial audio stream into parallel samples. It receives a bit clock, a frame clock and one serial data line, all as plain inputs. It samples them into its own system clock and rebuilds each channel's word. The block is always a slave: it never drives the bit clock or the frame clock.

Four word alignments can be chosen at run time: I2S, left-justified, right-justified, and a pulse-framed DSP format. A second input sets the word width, from 16 to 24 bits. In right-justified framing the word is aligned to the end of the half-frame, so the width setting decides where its MSB sits. Every finished word appears on a 24-bit output, left-aligned, with a one-cycle valid strobe and a tag that says which channel it belongs to.

Top module: `audio_serial_rx`

## Requirements
- R1: fmtSel encodes the alignment as 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = DSP. Because 0 is I2S, a block whose configuration is held at zero after reset runs in I2S.
- R2: In I2S, the MSB is sampled on the second rising bit clock after a frame clock transition. The word's remaining bits follow MSB first on the next rising edges.
- R3: In left-justified framing, the MSB is sampled on the first rising bit clock after a frame clock transition, and the rest follow MSB first.
- R4: In right-justified framing, the LSB is sampled on the 32nd rising bit clock of a 32-bit half-frame. The MSB therefore lands on position 32 minus the word width, counting from 0 at the first rising edge after the transition.
- R5: In DSP framing, a frame clock high on a rising bit clock marks the start of a frame. The left word starts on the next rising edge, and the right word follows with no gap. The channel is taken from position alone.
- R6: Outside DSP framing, sampleRight is 0 for words received while the frame clock is low and 1 for words received while it is high.
- R7: widthSel encodes the word width as 0 = 24, 1 = 20, 2 = 18, 3 = 16 bits. Narrower words are placed in the top bits of sampleOut, and the unused low bits are 0.
- R8: Each channel word produces exactly one sampleValid pulse, one system clock long.
- R9: Data bits outside the word's slots in the frame have no effect on any output.
- R10: While reset is held and right after it, sampleValid is 0 and sampleOut is 0.
- R11: Serial data is taken only at the rising bit clock. Changes on the data line while the bit clock is high do not alter the received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and outputs are in this domain |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | Serial bit clock from the external source |
| lrclkIn | input | 1 | Frame clock: channel select, or the frame pulse in DSP framing |
| sdataIn | input | 1 | Serial audio data, MSB first |
| fmtSel | input | 2 | Alignment select (see R1) |
| widthSel | input | 2 | Word width select (see R7) |
| sampleOut | output | 24 | Received word, left-aligned and zero-filled |
| sampleValid | output | 1 | One-cycle strobe when sampleOut holds a new word |
| sampleRight | output | 1 | Channel tag of the word: 0 left, 1 right |

## Verification
A position counter that is off by one shows as sampleOut values shifted by one bit. It also shows as a missing or extra valid pulse for the word that straddles the slot boundary. Either one appears within the first frame after the configuration settles.

A wrong channel decode shows as swapped sampleRight tags on the very next word. A wrong width decode shows as nonzero low bits or lost top bits. Random noise in the unused slots and a deliberate data flip during each bit clock high phase make any wrong sampling point visible within one frame.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_PULSE = 2'd3
  } fmt_e;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic shiftEn;
    logic emit;
    logic chanRight;
  } rxStrobe_t;

  // Word width in bits for a width code, given the widest word.
  function automatic int widthOf(input logic [1:0] sel, input int maxW);
    case (sel)
      2'd0:    return maxW;
      2'd1:    return maxW - 4;
      2'd2:    return maxW - 6;
      default: return maxW - 8;
    endcase
  endfunction

endpackage

// File: rtl/asrx_sync.sv
module asrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bclkIn,
  input  logic lrIn,
  input  logic dataIn,
  output logic bclkRise,
  output logic lrBit,
  output logic dataBit
);

  logic [STAGES:0]   bclkPipe;
  logic [STAGES-1:0] lrPipe;
  logic [STAGES-1:0] dataPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkPipe <= '0;
      lrPipe   <= '0;
      dataPipe <= '0;
    end else begin
      bclkPipe <= {bclkPipe[STAGES-1:0], bclkIn};
      lrPipe   <= {lrPipe[STAGES-2:0], lrIn};
      dataPipe <= {dataPipe[STAGES-2:0], dataIn};
    end
  end

  assign bclkRise = bclkPipe[STAGES-1] & ~bclkPipe[STAGES];
  assign lrBit    = lrPipe[STAGES-1];
  assign dataBit  = dataPipe[STAGES-1];

endmodule

// File: rtl/asrx_ctrl.sv
module asrx_ctrl
  import asrx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int HALF_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclkRise,
  input  logic       lrBit,
  input  fmt_e       fmtSel,
  input  logic [1:0] widthSel,
  output rxStrobe_t  strobe
);

  localparam int POS_W = $clog2(2 * HALF_BITS);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] posNext;
  logic             lrPrev;
  logic             marker;
  logic             inWin;
  logic             lastBit;
  logic             isRight;
  int               wordW;
  int               posI;

  always_comb begin
    wordW   = widthOf(widthSel, SAMPLE_W);
    marker  = (fmtSel == FMT_PULSE) ? lrBit : (lrBit != lrPrev);
    posNext = marker ? '0 : ((pos == POS_MAX) ? pos : pos + 1'b1);
    posI    = int'(posNext);
    isRight = lrBit;
    case (fmtSel)
      FMT_I2S: begin
        inWin   = (posI >= 1) && (posI <= wordW);
        lastBit = (posI == wordW);
      end
      FMT_LEFT: begin
        inWin   = (posI < wordW);
        lastBit = (posI == wordW - 1);
      end
      FMT_RIGHT: begin
        inWin   = (posI >= HALF_BITS - wordW) && (posI <= HALF_BITS - 1);
        lastBit = (posI == HALF_BITS - 1);
      end
      default: begin
        inWin   = (posI >= 1) && (posI <= 2 * wordW);
        lastBit = (posI == wordW) || (posI == 2 * wordW);
        isRight = (posI > wordW);
      end
    endcase
    strobe.shiftEn   = bclkRise & inWin;
    strobe.emit      = bclkRise & lastBit;
    strobe.chanRight = isRight;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos    <= POS_MAX;
      lrPrev <= 1'b0;
    end else if (bclkRise) begin
      pos    <= posNext;
      lrPrev <= lrBit;
    end
  end

  // R9: a word ends only on a bit that is itself part of the word
  assert_emit_in_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> strobe.shiftEn);

  // R11: the frame position moves only on a sampled rising bit clock
  assert_pos_on_edge_R11: assert property (@(posedge clk) disable iff (!rstN)
    !bclkRise |=> $stable(pos));

endmodule

// File: rtl/asrx_datapath.sv
module asrx_datapath
  import asrx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dataBit,
  input  rxStrobe_t           strobe,
  input  logic [1:0]          widthSel,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleValid,
  output logic                sampleRight
);

  logic [SAMPLE_W-1:0] shiftReg;
  logic [SAMPLE_W-1:0] assembled;
  logic [SAMPLE_W-1:0] aligned;
  int                  padShift;

  always_comb begin
    assembled = {shiftReg[SAMPLE_W-2:0], dataBit};
    padShift  = SAMPLE_W - widthOf(widthSel, SAMPLE_W);
    aligned   = assembled << padShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
      sampleRight <= 1'b0;
    end else begin
      sampleValid <= strobe.emit;
      if (strobe.shiftEn) shiftReg <= assembled;
      if (strobe.emit) begin
        sampleOut   <= aligned;
        sampleRight <= strobe.chanRight;
      end
    end
  end

  // R8: a valid strobe never lasts more than one cycle
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R7: a 16-bit word leaves the low bits zero
  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && $past(widthSel) == 2'd3) |-> (sampleOut[SAMPLE_W-17:0] == '0));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asrx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bclkIn,
  input  logic        lrclkIn,
  input  logic        sdataIn,
  input  logic [1:0]  fmtSel,
  input  logic [1:0]  widthSel,
  output logic [23:0] sampleOut,
  output logic        sampleValid,
  output logic        sampleRight
);

  localparam int SAMPLE_W  = 24;
  localparam int HALF_BITS = 32;

  logic      bclkRise;
  logic      lrBit;
  logic      dataBit;
  rxStrobe_t strobe;

  asrx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .lrIn(lrclkIn), .dataIn(sdataIn),
    .bclkRise(bclkRise), .lrBit(lrBit), .dataBit(dataBit)
  );

  asrx_ctrl #(.SAMPLE_W(SAMPLE_W), .HALF_BITS(HALF_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .bclkRise(bclkRise), .lrBit(lrBit),
    .fmtSel(fmt_e'(fmtSel)), .widthSel(widthSel), .strobe(strobe)
  );

  asrx_datapath #(.SAMPLE_W(SAMPLE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .dataBit(dataBit), .strobe(strobe),
    .widthSel(widthSel), .sampleOut(sampleOut), .sampleValid(sampleValid),
    .sampleRight(sampleRight)
  );

endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bclkIn = 1'b0;
  logic        lrclkIn = 1'b0;
  logic        sdataIn = 1'b0;
  logic [1:0]  fmtSel = 2'd0;
  logic [1:0]  widthSel = 2'd0;
  logic [23:0] sampleOut;
  logic        sampleValid;
  logic        sampleRight;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  logic [23:0] expData [0:15];
  logic        expRight[0:15];
  logic [23:0] gotData [0:15];
  logic        gotRight[0:15];
  int expN = 0;
  int gotN = 0;

  always #2.5 clk = ~clk;

  audio_serial_rx u_dut (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdataIn(sdataIn),
    .fmtSel(fmtSel), .widthSel(widthSel), .sampleOut(sampleOut),
    .sampleValid(sampleValid), .sampleRight(sampleRight)
  );

  always @(negedge clk) begin
    if (rstN && sampleValid) begin
      if (gotN < 16) begin
        gotData[gotN]  = sampleOut;
        gotRight[gotN] = sampleRight;
      end
      gotN = gotN + 1;
    end
  end

  function automatic int wordBits(input logic [1:0] w);
    case (w)
      2'd0: return 24;
      2'd1: return 20;
      2'd2: return 18;
      default: return 16;
    endcase
  endfunction

  function automatic string fmtTag(input logic [1:0] f);
    case (f)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [23:0] expectWord(input logic [23:0] v, input logic [1:0] w);
    return v & (24'hFFFFFF << (24 - wordBits(w)));
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  endtask

  // One bit clock period: data set on the falling edge, flipped late in the high phase (R11).
  task automatic bitOut(input logic lr, input logic d);
    @(negedge clk);
    bclkIn  = 1'b0;
    lrclkIn = lr;
    sdataIn = d;
    repeat (4) @(negedge clk);
    bclkIn = 1'b1;
    repeat (3) @(negedge clk);
    sdataIn = ~d;
  endtask

  task automatic idle(input int n, input logic lr);
    for (int i = 0; i < n; i++) bitOut(lr, 1'($urandom));
  endtask

  task automatic sendFrame(input logic [1:0] f, input logic [1:0] wsel,
                           input logic [23:0] l, input logic [23:0] r);
    int W;
    logic [23:0] lw, rw, word;
    W  = wordBits(wsel);
    lw = l >> (24 - W);
    rw = r >> (24 - W);
    if (f == 2'd3) begin
      for (int j = 0; j < 64; j++) begin
        if (j >= 1 && j <= W)          bitOut(j == 0, lw[W - j]);
        else if (j > W && j <= 2 * W)  bitOut(j == 0, rw[2 * W - j]);
        else                           bitOut(j == 0, 1'($urandom));
      end
    end else begin
      for (int h = 0; h < 2; h++) begin
        word = (h == 0) ? lw : rw;
        for (int j = 0; j < 32; j++) begin
          if (f == 2'd0 && j >= 1 && j <= W)        bitOut(h[0], word[W - j]);
          else if (f == 2'd1 && j < W)              bitOut(h[0], word[W - 1 - j]);
          else if (f == 2'd2 && j >= 32 - W)        bitOut(h[0], word[31 - j]);
          else                                      bitOut(h[0], 1'($urandom)); // R9 noise
        end
      end
    end
    expData[expN] = expectWord(l, wsel); expRight[expN] = 1'b0; expN++;
    expData[expN] = expectWord(r, wsel); expRight[expN] = 1'b1; expN++;
  endtask

  task automatic runBatch(input logic [1:0] f, input logic [1:0] wsel,
                          input int frames, input bit directed, input string extra);
    logic idleLr;
    logic [23:0] l, r;
    fmtSel   = f;
    widthSel = wsel;
    idleLr   = (f == 2'd3) ? 1'b0 : 1'b1;
    idle(64, idleLr);
    gotN = 0;
    expN = 0;
    for (int k = 0; k < frames; k++) begin
      l = 24'($urandom);
      r = 24'($urandom);
      if (directed && k == 0) begin l = 24'hFFFFFF; r = 24'h800000; end
      if (directed && k == 1) begin l = 24'h000001 << (24 - wordBits(wsel)); r = 24'h5A5A5A; end
      sendFrame(f, wsel, l, r);
    end
    idle(4, idleLr);
    // R8: one valid pulse per channel word
    checkCount++;
    if (gotN != expN) begin
      failCount++;
      $display("FAIL R8%s %s fmt=%0d w=%0d valid count got %0d exp %0d",
               extra, fmtTag(f), f, wsel, gotN, expN);
    end
    for (int i = 0; i < expN && i < gotN; i++) begin
      checkCount++;
      if (gotData[i] !== expData[i]) begin
        failCount++;
        $display("FAIL %s/R7/R9/R11 fmt=%0d w=%0d word %0d got %h exp %h",
                 fmtTag(f), f, wsel, i, gotData[i], expData[i]);
      end
      checkCount++;
      if (gotRight[i] !== expRight[i]) begin
        failCount++;
        $display("FAIL %s fmt=%0d word %0d channel got %0d exp %0d",
                 (f == 2'd3) ? "R5" : "R6", f, i, gotRight[i], expRight[i]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R10: outputs idle during reset
    checkCount++;
    if (sampleValid !== 1'b0 || sampleOut !== 24'd0) begin
      failCount++;
      $display("FAIL R10 in reset valid=%0d data=%h exp 0/000000", sampleValid, sampleOut);
    end
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkCount++;
    if (sampleValid !== 1'b0 || sampleOut !== 24'd0) begin
      failCount++;
      $display("FAIL R10 after reset valid=%0d data=%h exp 0/000000", sampleValid, sampleOut);
    end
    // R1: configuration left at zero gives I2S with 24-bit words
    runBatch(2'd0, 2'd0, 2, 1'b1, "/R1");
    for (int f = 0; f < 4; f++)
      for (int w = 0; w < 4; w++)
        runBatch(2'(f), 2'(w), 2, 1'b1, "");
    for (int b = 0; b < 10; b++)
      runBatch(2'($urandom), 2'($urandom), 3, 1'b0, "");
    finishRun();
  end

endmodule